// File: doc/BRIEF.md
# Quarter-Rate IQ Downconverter

This block turns a stream of signed real samples into complex baseband. It mixes the stream with a carrier at exactly one quarter of the sample rate, for example 25 MHz on a 100 MS/s stream. At that frequency every carrier value is +1, -1 or 0. The mix therefore needs only sign changes and no multipliers. Each sample lands in one channel only: it feeds I on even phases and Q on odd phases. The samples that the other channel's carrier would zero out are simply never used. The result is an I stream and a Q stream, each at half the input rate, emitted together as one pair for every two accepted input samples.

A free-running 2-bit phase counter tracks the carrier position. It starts from phase 0 after reset and advances only on accepted samples. Both sides of the block are valid/ready streams. An input sample is accepted when `in_valid` and `in_ready` are both high on a rising edge. An output pair is consumed when `out_valid` and `out_ready` are both high. While a completed pair waits for `out_ready`, the block holds `out_i` and `out_q` steady and drives `in_ready` low. This back-pressure stalls the input stream, so no sample is lost and the phase does not drift. Filtering before or after the block is the surrounding system's job.

Top module: `quarter_rate_iq_mixer`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1, and the first sample accepted after reset is taken as phase 0. A reset in the middle of a pair discards the half-built pair.
- R2: A sample accepted at phase 0 becomes the I value of its pair, sign-extended unchanged to DATA_W+1 bits (carrier +1).
- R3: A sample accepted at phase 2 becomes the I value of its pair, negated in DATA_W+1 bit two's complement (carrier -1).
- R4: A sample accepted at phase 1 becomes the Q value of its pair, negated (carrier -1).
- R5: A sample accepted at phase 3 becomes the Q value of its pair, sign-extended unchanged (carrier +1).
- R6: Negating the most negative input (-2^(DATA_W-1)) yields +2^(DATA_W-1) with no overflow, because outputs are one bit wider than the input.
- R7: `out_valid` rises on the cycle after the edge that accepts the odd-phase (second) sample of a pair. It never rises after an even-phase sample.
- R8: The phase advances by one (mod 4) only on an accepted sample. Cycles without an accepted sample leave it unchanged.
- R9: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_i`/`out_q`/`out_valid` hold their values.
- R10: With `out_ready` held high, each pair is presented for exactly one cycle, giving one pair per two input samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can accept a sample this cycle |
| in_sample | input | DATA_W | Signed real input sample |
| out_valid | output | 1 | I/Q pair present |
| out_ready | input | 1 | Consumer accepts the pair this cycle |
| out_i | output | DATA_W+1 | Signed in-phase output |
| out_q | output | DATA_W+1 | Signed quadrature output |

## Verification
The embedded properties check the following on every cycle:
- the phase holds on cycles without an accepted sample;
- a stalled pair stays stable, and input is refused during the stall;
- a completed odd-phase sample is always followed by a valid pair, and a pair never appears without one;
- a negated negative sample never comes out negative.

Only the bench scenarios can show the actual sign applied at each of the four phases and the exact values at the most negative input. They also show that a sample offered during a stall is truly not taken, and that a reset in mid-pair restarts the carrier at phase 0.

// File: rtl/iq4_pkg.sv
package iq4_pkg;
  // carrier position; the order is the carrier sequence and must not change
  typedef enum logic [1:0] {
    PH_I_POS = 2'd0,  // I carrier +1, Q carrier 0
    PH_Q_NEG = 2'd1,  // I carrier 0,  Q carrier -1
    PH_I_NEG = 2'd2,  // I carrier -1, Q carrier 0
    PH_Q_POS = 2'd3   // I carrier 0,  Q carrier +1
  } carrier_ph_e;

  function automatic logic ph_negates(input carrier_ph_e ph);
    return (ph == PH_Q_NEG) || (ph == PH_I_NEG);
  endfunction

  function automatic logic ph_is_q(input carrier_ph_e ph);
    return ph[0];
  endfunction
endpackage

// File: rtl/iq4_phase_ctr.sv
module iq4_phase_ctr
  import iq4_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv,
  output carrier_ph_e phase
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_I_POS;
    else if (adv) phase <= carrier_ph_e'(phase + 2'd1);
  end

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(phase)); // R8
endmodule

// File: rtl/iq4_sign_mix.sv
module iq4_sign_mix
  import iq4_pkg::*;
#(
  parameter int DATA_W = 12,
  localparam int OUT_W = DATA_W + 1
) (
  input  logic signed [DATA_W-1:0] din,
  input  carrier_ph_e              phase,
  output logic signed [OUT_W-1:0]  dout
);
  logic signed [OUT_W-1:0] widened;
  logic                    flip;

  always_comb begin
    widened = {din[DATA_W-1], din};
    flip    = ph_negates(phase);
    dout    = flip ? -widened : widened;
  end

  always_comb begin
    if (!$isunknown(din) && !$isunknown(phase) && flip && din[DATA_W-1])
      AST_NEG_NO_WRAP: assert (!dout[OUT_W-1]); // R6
  end
endmodule

// File: rtl/iq4_pair_reg.sv
module iq4_pair_reg #(
  parameter int OUT_W = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic                    load_q,
  input  logic signed [OUT_W-1:0] mixed,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_i,
  output logic signed [OUT_W-1:0] out_q
);
  logic signed [OUT_W-1:0] held_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_i    <= '0;
      out_i     <= '0;
      out_q     <= '0;
      out_valid <= 1'b0;
    end else begin
      if (load_i) held_i <= mixed;
      if (load_q) begin
        out_i     <= held_i;
        out_q     <= mixed;
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_PAIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_i) && $stable(out_q)); // R9
  AST_SINGLE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !load_q |=> !out_valid); // R10
endmodule

// File: rtl/quarter_rate_iq_mixer.sv
module quarter_rate_iq_mixer
  import iq4_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_sample,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [DATA_W:0]   out_i,
  output logic signed [DATA_W:0]   out_q
);
  localparam int OUT_W = DATA_W + 1;

  carrier_ph_e             phase;
  logic                    accept;
  logic signed [OUT_W-1:0] mixed;

  assign in_ready = !(out_valid && !out_ready);
  assign accept   = in_valid && in_ready;

  iq4_phase_ctr u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (accept),
    .phase (phase)
  );

  iq4_sign_mix #(.DATA_W(DATA_W)) u_mix (
    .din   (in_sample),
    .phase (phase),
    .dout  (mixed)
  );

  iq4_pair_reg #(.OUT_W(OUT_W)) u_pair (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (accept && !ph_is_q(phase)),
    .load_q    (accept && ph_is_q(phase)),
    .mixed     (mixed),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q)
  );

  AST_STALL_BLOCKS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R9
  AST_PAIR_FOLLOWS_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    accept && phase[0] |=> out_valid); // R7
  AST_NO_PAIR_FROM_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(accept && phase[0])); // R7
endmodule

// File: tb/test_quarter_rate_iq_mixer.sv
module test_quarter_rate_iq_mixer;
  localparam int W  = 12;
  localparam int OW = W + 1;
  localparam int NV = 6;

  // {even sample, odd sample, expected I, expected Q}; rows alternate phases 0/1 and 2/3
  typedef struct packed {
    logic signed [W-1:0]  s_even;
    logic signed [W-1:0]  s_odd;
    logic signed [OW-1:0] e_i;
    logic signed [OW-1:0] e_q;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{12'sd100,   12'sd7,     13'sd100,   -13'sd7},    // R2 R4
    '{12'sd50,   -12'sd30,   -13'sd50,   -13'sd30},    // R3 R5
    '{-12'sd2048, -12'sd2048, -13'sd2048, 13'sd2048},  // R6 via Q
    '{-12'sd2048, 12'sd2047,  13'sd2048,  13'sd2047},  // R6 via I
    '{12'sd2047,  12'sd1,     13'sd2047,  -13'sd1},    // R2 R4
    '{-12'sd1,   -12'sd5,     13'sd1,    -13'sd5}      // R3 R5
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [W-1:0] in_sample = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [OW-1:0] out_i, out_q;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  quarter_rate_iq_mixer #(.DATA_W(W)) i_quarter_rate_iq_mixer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .out_valid(out_valid), .out_ready(out_ready),
    .out_i(out_i), .out_q(out_q)
  );

  task automatic check(input string req, input logic signed [OW-1:0] act,
                       input logic signed [OW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // inputs change only at falling edges; returns at the next falling edge
  task automatic push(input logic signed [W-1:0] s);
    in_valid  = 1'b1;
    in_sample = s;
    @(negedge clk);
    in_valid  = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(2);
    check("R1 out_valid after reset", OW'(out_valid), 0);
    check("R1 in_ready after reset", OW'(in_ready), 1);
    rst_n = 1'b1;
    idle(1);

    // table walk, back-to-back samples
    for (int v = 0; v < NV; v++) begin
      push(VECS[v].s_even);
      check("R7/R10 no pair after even sample", OW'(out_valid), 0);
      push(VECS[v].s_odd);
      check("R7 pair after odd sample", OW'(out_valid), 1);
      check("R2/R3/R6 I value", out_i, VECS[v].e_i);
      check("R4/R5/R6 Q value", out_q, VECS[v].e_q);
    end
    idle(1);
    check("R10 pair lasts one cycle", OW'(out_valid), 0);

    // idle gap inside a pair: phase must not move (now at phase 0)
    push(12'sd300);
    idle(5);
    check("R8 no pair during gap", OW'(out_valid), 0);
    push(12'sd4);
    check("R8 I after gap", out_i, 13'sd300);
    check("R8 Q after gap", out_q, -13'sd4);
    idle(1);

    // back-pressure (phase 2/3)
    out_ready = 1'b0;
    push(12'sd10);
    push(12'sd20);
    check("R3 I before stall", out_i, -13'sd10);
    check("R5 Q before stall", out_q, 13'sd20);
    in_valid  = 1'b1;
    in_sample = 12'sd99;
    idle(3);
    check("R9 valid held", OW'(out_valid), 1);
    check("R9 in_ready low", OW'(in_ready), 0);
    check("R9 I held", out_i, -13'sd10);
    check("R9 Q held", out_q, 13'sd20);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    idle(1);
    check("R9 pair drained", OW'(out_valid), 0);
    push(12'sd99);
    push(12'sd5);
    check("R9 stalled sample not taken: I", out_i, 13'sd99);
    check("R9 stalled sample not taken: Q", out_q, -13'sd5);
    idle(1);

    // reset in the middle of a pair
    push(12'sd7);
    rst_n = 1'b0;
    idle(1);
    check("R1 mid-pair reset clears valid", OW'(out_valid), 0);
    rst_n = 1'b1;
    idle(1);
    push(12'sd8);
    check("R1 no pair from first sample", OW'(out_valid), 0);
    push(12'sd9);
    check("R1 restart I at phase 0", out_i, 13'sd8);
    check("R1 restart Q at phase 1", out_q, -13'sd9);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule